// File: doc/BRIEF.md
# Boot-Swap Memory Chip-Select Decoder

This block turns each bus access of a microcontroller that has separate program and data address spaces into one chip-select for an external memory segment. There are eight 64 KB main flash segments, four 8 KB secondary flash segments and a single 8 KB SRAM. The two low secondary segments hold the boot loader. The two high secondary segments are spare storage. The access kind comes from three active-high strobes: a program fetch strobe and data read and data write strobes.

Two 8-bit registers set the map at run time, and both are written through a small register port. The placement register chooses whether main flash and secondary flash can be seen in program space, in data space, or in both. The page register carries two controls. The exchange bit takes the boot loader out of the low program window and puts main flash segment 0 there. The unlock bit allows writes into the boot loader segments.

Firmware steps through the map in a fixed order. Out of reset it runs the loader from secondary flash, with main flash visible as data. It then maps main flash into program space, sets the exchange bit, and finally moves all of secondary flash into data space.

Top module: `boot_swap_decoder`

## Requirements
- R1: When reset is asserted (asynchronous, active low), the placement register becomes 12h and the page register becomes 00h.
- R2: When `reg_we` is high at a clock edge, `reg_wdata` is stored in the placement register if `reg_sel`=0 or in the page register if `reg_sel`=1. The new value takes effect from the next cycle. An access in the same cycle as the write is decoded with the old values.
- R3: When placement bit 2 is set, a fetch at `i*10000h` to `i*10000h+FFFFh` (i = 0 to 7) selects `cs_main[i]`. Address bits 19 to 16 give the segment number.
- R4: When placement bit 1 is set and page bit 7 is clear, a fetch at 0000h to 1FFFh selects `cs_sec[0]` and a fetch at 2000h to 3FFFh selects `cs_sec[1]`. This boot window takes priority over main flash.
- R5: When page bit 7 is set, no fetch selects `cs_sec[1:0]`. A fetch at 0000h to 3FFFh then selects `cs_main[0]` if placement bit 2 is set, and selects nothing otherwise.
- R6: When placement bit 4 is set, a data access at 00000h to 7FFFFh selects `cs_main[addr[19:16]]`. When bit 4 is clear, such an access selects nothing.
- R7: When placement bit 3 is set, a data access at `80000h+n*2000h` (n = 0 to 3) selects `cs_sec[n]`. For n = 2 and n = 3 this happens only while page bit 7 is set.
- R8: A data access at 90000h to 91FFFh selects `cs_sram`, whatever the register contents.
- R9: At most one chip-select is active. None is active when no strobe is active or when the address is not mapped.
- R10: `mem_wr` is high on a data write that selects a segment. For `cs_sec[0]` and `cs_sec[1]` it is high only while page bit 6 is set. The chip-select stays active even when the write is blocked.
- R11: A fetch takes priority over data strobes active in the same cycle. `mem_rd` is high on a fetch or a data read that selects a segment, and `mem_wr` is never high during a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 = placement, 1 = page |
| reg_wdata | input | 8 | Register write data |
| addr | input | 20 | Access address |
| prog_rd | input | 1 | Program fetch strobe |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| cs_main | output | 8 | Main flash segment selects |
| cs_sec | output | 4 | Secondary flash segment selects |
| cs_sram | output | 1 | SRAM select |
| mem_rd | output | 1 | Qualified read strobe |
| mem_wr | output | 1 | Qualified write strobe |
| mode_q | output | 8 | Placement register contents |
| page_q | output | 8 | Page register contents |

## Verification
A register write and a memory access can happen in the same cycle. The bench forces this by writing 06h to the placement register while it fetches from 50000h. That fetch must select nothing, because it is decoded under the reset map. The same fetch one cycle later must select `cs_main[5]`. The scoreboard holds the expected chip-selects for each cycle, so any change that applies a register write too early or too late shows up as a mismatch in one of those two cycles.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_FETCH,
        ACC_READ,
        ACC_WRITE
    } acc_kind_t;

    // placement register fields
    localparam int MODE_SEC_PROG  = 1;
    localparam int MODE_MAIN_PROG = 2;
    localparam int MODE_SEC_DATA  = 3;
    localparam int MODE_MAIN_DATA = 4;

    // page register fields
    localparam int PAGE_UNLOCK = 6;
    localparam int PAGE_SWAP   = 7;

    localparam logic [7:0] MODE_RESET = 8'h12;
    localparam logic [7:0] PAGE_RESET = 8'h00;

    localparam logic SEL_MODE = 1'b0;
    localparam logic SEL_PAGE = 1'b1;

endpackage

// File: rtl/bsd_regs.sv
module bsd_regs
    import bsd_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mode_q,
    output logic [REG_W-1:0] page_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= REG_W'(MODE_RESET);
            page_q <= REG_W'(PAGE_RESET);
        end else if (we) begin
            if (sel == SEL_MODE) mode_q <= wdata;
            else                 page_q <= wdata;
        end
    end

endmodule

// File: rtl/bsd_access_cls.sv
module bsd_access_cls
    import bsd_pkg::*;
(
    input  logic      prog_rd,
    input  logic      data_rd,
    input  logic      data_wr,
    output acc_kind_t kind
);

    always_comb begin
        if (prog_rd)      kind = ACC_FETCH;
        else if (data_wr) kind = ACC_WRITE;
        else if (data_rd) kind = ACC_READ;
        else              kind = ACC_IDLE;
    end

endmodule

// File: rtl/bsd_seg_dec.sv
module bsd_seg_dec #(
    parameter int          ADDR_W = 20,
    parameter int          SEG_W  = 16,
    parameter int          SEGS   = 8,
    parameter int unsigned BASE   = 0
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [SEGS-1:0]   hit
);

    localparam int TAG_W = ADDR_W - SEG_W;

    logic [TAG_W-1:0] tag;
    logic             unused_low_bits;

    assign tag             = addr[ADDR_W-1:SEG_W];
    assign unused_low_bits = ^addr[SEG_W-1:0];

    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        localparam logic [TAG_W-1:0] SEG_TAG = TAG_W'((BASE >> SEG_W) + i);
        assign hit[i] = en && (tag == SEG_TAG);
    end

endmodule

// File: rtl/bsd_wr_gate.sv
module bsd_wr_gate
    import bsd_pkg::*;
(
    input  acc_kind_t kind,
    input  logic      any_cs,
    input  logic      boot_cs,
    input  logic      unlock,
    output logic      mem_rd,
    output logic      mem_wr
);

    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        unique case (kind)
            ACC_FETCH,
            ACC_READ:  mem_rd = any_cs;
            ACC_WRITE: mem_wr = any_cs && (!boot_cs || unlock);
            ACC_IDLE:  ;
        endcase
    end

endmodule

// File: rtl/boot_swap_decoder.sv
module boot_swap_decoder
    import bsd_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          REG_W      = 8,
    parameter int          MAIN_SEGS  = 8,
    parameter int          MAIN_SEG_W = 16,
    parameter int          SEC_SEGS   = 4,
    parameter int          SEC_SEG_W  = 13,
    parameter int          SRAM_W     = 13,
    parameter int unsigned SEC_BASE   = 32'h8_0000,
    parameter int unsigned SRAM_BASE  = 32'h9_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 prog_rd,
    input  logic                 data_rd,
    input  logic                 data_wr,
    output logic [MAIN_SEGS-1:0] cs_main,
    output logic [SEC_SEGS-1:0]  cs_sec,
    output logic                 cs_sram,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [REG_W-1:0]     mode_q,
    output logic [REG_W-1:0]     page_q
);

    localparam int BOOT_SEGS = SEC_SEGS / 2;
    localparam int EXT_SEGS  = SEC_SEGS - BOOT_SEGS;

    acc_kind_t            kind;
    logic                 is_fetch;
    logic                 is_data;
    logic                 swap;
    logic                 unlock;
    logic [MAIN_SEGS-1:0] main_raw;
    logic [BOOT_SEGS-1:0] boot_raw;
    logic [BOOT_SEGS-1:0] boot_sel;
    logic [SEC_SEGS-1:0]  sec_raw;
    logic [SEC_SEGS-1:0]  sec_mask;
    logic [0:0]           sram_raw;
    logic                 main_en;

    bsd_regs #(.REG_W(REG_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .mode_q (mode_q),
        .page_q (page_q)
    );

    bsd_access_cls u_cls (
        .prog_rd (prog_rd),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .kind    (kind)
    );

    assign is_fetch = (kind == ACC_FETCH);
    assign is_data  = (kind == ACC_READ) || (kind == ACC_WRITE);
    assign swap     = page_q[PAGE_SWAP];
    assign unlock   = page_q[PAGE_UNLOCK];

    // boot window in program space, removed by the exchange bit
    bsd_seg_dec #(
        .ADDR_W (ADDR_W), .SEG_W (SEC_SEG_W), .SEGS (BOOT_SEGS), .BASE (0)
    ) u_boot_dec (
        .en   (is_fetch && mode_q[MODE_SEC_PROG] && !swap),
        .addr (addr),
        .hit  (boot_raw)
    );
    assign boot_sel = boot_raw;

    // main flash, either space
    assign main_en = (is_fetch && mode_q[MODE_MAIN_PROG] && !(|boot_sel))
                   || (is_data && mode_q[MODE_MAIN_DATA]);

    bsd_seg_dec #(
        .ADDR_W (ADDR_W), .SEG_W (MAIN_SEG_W), .SEGS (MAIN_SEGS), .BASE (0)
    ) u_main_dec (
        .en   (main_en),
        .addr (addr),
        .hit  (main_raw)
    );
    assign cs_main = main_raw;

    // secondary flash in data space
    bsd_seg_dec #(
        .ADDR_W (ADDR_W), .SEG_W (SEC_SEG_W), .SEGS (SEC_SEGS), .BASE (SEC_BASE)
    ) u_sec_dec (
        .en   (is_data && mode_q[MODE_SEC_DATA]),
        .addr (addr),
        .hit  (sec_raw)
    );

    for (genvar n = 0; n < SEC_SEGS; n++) begin : g_sec_mask
        if (n < BOOT_SEGS) begin : g_boot
            assign sec_mask[n] = 1'b1;
        end else begin : g_ext
            assign sec_mask[n] = swap;
        end
    end

    assign cs_sec = (sec_raw & sec_mask) | {{EXT_SEGS{1'b0}}, boot_sel};

    // SRAM at a fixed data window
    bsd_seg_dec #(
        .ADDR_W (ADDR_W), .SEG_W (SRAM_W), .SEGS (1), .BASE (SRAM_BASE)
    ) u_sram_dec (
        .en   (is_data),
        .addr (addr),
        .hit  (sram_raw)
    );
    assign cs_sram = sram_raw[0];

    bsd_wr_gate u_gate (
        .kind    (kind),
        .any_cs  ((|cs_main) || (|cs_sec) || cs_sram),
        .boot_cs (|cs_sec[BOOT_SEGS-1:0]),
        .unlock  (unlock),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr)
    );

endmodule

// File: rtl/boot_swap_decoder_chk.sv
module boot_swap_decoder_chk #(
    parameter int          ADDR_W    = 20,
    parameter int          REG_W     = 8,
    parameter int          MAIN_SEGS = 8,
    parameter int          SEC_SEGS  = 4,
    parameter int          SRAM_W    = 13,
    parameter int unsigned SRAM_BASE = 32'h9_0000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic                 reg_sel,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [ADDR_W-1:0]    addr,
    input logic                 prog_rd,
    input logic                 data_rd,
    input logic                 data_wr,
    input logic [MAIN_SEGS-1:0] cs_main,
    input logic [SEC_SEGS-1:0]  cs_sec,
    input logic                 cs_sram,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [REG_W-1:0]     mode_q,
    input logic [REG_W-1:0]     page_q
);

    localparam int TAG_W = ADDR_W - SRAM_W;
    localparam logic [TAG_W-1:0] SRAM_TAG = TAG_W'(SRAM_BASE >> SRAM_W);

    logic in_sram;
    assign in_sram = (addr[ADDR_W-1:SRAM_W] == SRAM_TAG);

    // R2
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel) |=> (mode_q == $past(reg_wdata)));

    // R2
    page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel) |=> (page_q == $past(reg_wdata)));

    // R9
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_main, cs_sec, cs_sram}));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_rd && !data_rd && !data_wr) |-> ({cs_main, cs_sec, cs_sram} == '0));

    // R5
    swap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_rd && page_q[7]) |-> (cs_sec[1:0] == 2'b00));

    // R7
    ext_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs_sec[3:2]) |-> page_q[7]);

    // R8
    sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_rd && (data_rd || data_wr) && in_sram) |-> cs_sram);

    // R10
    boot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && (|cs_sec[1:0])) |-> page_q[6]);

    // R11
    fetch_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_rd |-> !mem_wr);

    // R11
    rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ((prog_rd || data_rd) && !mem_wr && (mode_q == mode_q)));

endmodule

bind boot_swap_decoder boot_swap_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .REG_W     (REG_W),
    .MAIN_SEGS (MAIN_SEGS),
    .SEC_SEGS  (SEC_SEGS),
    .SRAM_W    (SRAM_W),
    .SRAM_BASE (SRAM_BASE)
) u_chk (.*);

// File: tb/test_boot_swap_decoder.sv
`timescale 1ns/1ps
module test_boot_swap_decoder;

    typedef struct {
        logic [7:0] m;
        logic [3:0] s;
        logic       r;
        logic       rd;
        logic       wr;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [19:0] addr = '0;
    logic        prog_rd = 1'b0;
    logic        data_rd = 1'b0;
    logic        data_wr = 1'b0;
    logic [7:0]  cs_main;
    logic [3:0]  cs_sec;
    logic        cs_sram;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mode_q;
    logic [7:0]  page_q;

    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    boot_swap_decoder i_boot_swap_decoder (
        .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .addr,
        .prog_rd, .data_rd, .data_wr, .cs_main, .cs_sec, .cs_sram,
        .mem_rd, .mem_wr, .mode_q, .page_q
    );

    // monitor: compare each expected item in the cycle it was driven
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cs_main !== e.m || cs_sec !== e.s || cs_sram !== e.r ||
                    mem_rd !== e.rd || mem_wr !== e.wr) begin
                    errors++;
                    $display("FAIL %s: got main=%h sec=%h sram=%b rd=%b wr=%b exp main=%h sec=%h sram=%b rd=%b wr=%b",
                             e.tag, cs_main, cs_sec, cs_sram, mem_rd, mem_wr,
                             e.m, e.s, e.r, e.rd, e.wr);
                end
            end
        end
    end

    task automatic acc(input logic [19:0] a, input logic p, input logic dr, input logic dw,
                       input logic [7:0] m, input logic [3:0] s, input logic r,
                       input logic rd, input logic wr, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        reg_we  = 1'b0;
        addr    = a;
        prog_rd = p;
        data_rd = dr;
        data_wr = dw;
        e.m = m; e.s = s; e.r = r; e.rd = rd; e.wr = wr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wreg(input logic sel, input logic [7:0] d);
        @(posedge clk);
        #1;
        prog_rd = 1'b0; data_rd = 1'b0; data_wr = 1'b0;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    endtask

    task automatic chk_reg(input logic [7:0] em, input logic [7:0] ep, input string tag);
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        #1;
        checks++;
        if (mode_q !== em || page_q !== ep) begin
            errors++;
            $display("FAIL %s: got mode=%h page=%h exp mode=%h page=%h", tag, mode_q, page_q, em, ep);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_reg(8'h12, 8'h00, "R1 reset values");

        // reset map: boot in program, main in data
        acc(20'h00100, 1, 0, 0, 8'h00, 4'b0001, 0, 1, 0, "R4 boot seg0");
        acc(20'h02000, 1, 0, 0, 8'h00, 4'b0010, 0, 1, 0, "R4 boot seg1");
        acc(20'h10000, 1, 0, 0, 8'h00, 4'b0000, 0, 0, 0, "R3 main not in prog");
        acc(20'h30000, 0, 1, 0, 8'h08, 4'b0000, 0, 1, 0, "R6 main data seg3");
        acc(20'h80000, 0, 1, 0, 8'h00, 4'b0000, 0, 0, 0, "R7 sec not in data");
        acc(20'h90010, 0, 0, 1, 8'h00, 4'b0000, 1, 0, 1, "R8 sram write");
        acc(20'hA0000, 0, 1, 0, 8'h00, 4'b0000, 0, 0, 0, "R9 unmapped");
        acc(20'h00000, 0, 0, 0, 8'h00, 4'b0000, 0, 0, 0, "R9 no strobe");
        acc(20'h00000, 1, 1, 0, 8'h00, 4'b0001, 0, 1, 0, "R11 fetch wins");
        acc(20'h00000, 1, 0, 1, 8'h00, 4'b0001, 0, 1, 0, "R11 no write on fetch");

        // same-cycle write and access: old map applies
        acc(20'h50000, 1, 0, 0, 8'h00, 4'b0000, 0, 0, 0, "R2 same cycle old map");
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h06;
        acc(20'h50000, 1, 0, 0, 8'h20, 4'b0000, 0, 1, 0, "R2 new map next cycle");
        chk_reg(8'h06, 8'h00, "R2 mode readback");

        acc(20'h00000, 1, 0, 0, 8'h00, 4'b0001, 0, 1, 0, "R4 boot priority");
        acc(20'h04000, 1, 0, 0, 8'h01, 4'b0000, 0, 1, 0, "R3 main seg0 above boot");
        acc(20'h7FFFF, 1, 0, 0, 8'h80, 4'b0000, 0, 1, 0, "R3 main seg7 top");
        acc(20'h10000, 0, 1, 0, 8'h00, 4'b0000, 0, 0, 0, "R6 main out of data");

        wreg(1'b1, 8'h80);
        chk_reg(8'h06, 8'h80, "R2 page readback");
        acc(20'h00000, 1, 0, 0, 8'h01, 4'b0000, 0, 1, 0, "R5 swap fs0 low");
        acc(20'h02000, 1, 0, 0, 8'h01, 4'b0000, 0, 1, 0, "R5 swap fs0 upper boot");

        wreg(1'b0, 8'h0C);
        acc(20'h80000, 0, 1, 0, 8'h00, 4'b0001, 0, 1, 0, "R7 sec0 data");
        acc(20'h86000, 0, 1, 0, 8'h00, 4'b1000, 0, 1, 0, "R7 sec3 with swap");
        acc(20'h82000, 0, 0, 1, 8'h00, 4'b0010, 0, 0, 0, "R10 boot write locked");
        acc(20'h84000, 0, 0, 1, 8'h00, 4'b0100, 0, 0, 1, "R10 ext write allowed");
        acc(20'h30000, 0, 1, 0, 8'h00, 4'b0000, 0, 0, 0, "R6 main data off");

        wreg(1'b1, 8'hC0);
        acc(20'h82000, 0, 0, 1, 8'h00, 4'b0010, 0, 0, 1, "R10 boot write unlocked");

        wreg(1'b1, 8'h40);
        acc(20'h86000, 0, 1, 0, 8'h00, 4'b0000, 0, 0, 0, "R7 sec3 hidden no swap");
        acc(20'h00000, 1, 0, 0, 8'h01, 4'b0000, 0, 1, 0, "R4 boot off in prog");
        acc(20'h91FFF, 0, 1, 0, 8'h00, 4'b0000, 1, 1, 0, "R8 sram top");

        @(posedge clk);
        #1 rst_n = 1'b0;
        prog_rd = 1'b0; data_rd = 1'b0; data_wr = 1'b0;
        #1;
        checks++;
        if (mode_q !== 8'h12 || page_q !== 8'h00) begin
            errors++;
            $display("FAIL R1 async reset: got mode=%h page=%h exp mode=12 page=00", mode_q, page_q);
        end
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        acc(20'h00000, 1, 0, 0, 8'h00, 4'b0001, 0, 1, 0, "R1 boot after reset");

        @(negedge clk);
        #1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule